// File: doc/BRIEF.md
# Debug Fetch Overlay Memory

This unit sits on the instruction-fetch path of a processor core whose register space holds 512 words. While a debug interrupt is being serviced, fetches that land in the eight words at the top of that space (0x1F8 to 0x1FF) are answered from a small writable overlay memory rather than from core RAM. The overlay holds the handler entry stub, so the code under debug does not need a resident stub of its own. At all other times, and for every address outside the window, the core RAM word passes through unchanged.

A debug-active flag is set by an entry pulse and stays set until an explicit clear pulse, which the last stub instruction issues. The unit provides the entry vector for the fetch sequencer. In normal entry mode the vector is the base of the window. In short-stub mode it is the second-to-last word, so a two-word stub runs at 0x1FE and 0x1FF. The unit also provides the sequential successor of the current fetch address, which wraps from 0x1FF to 0x000. The overlay is loaded through a write port from outside the unit. The overlay read has the same one-cycle latency as core RAM, so selecting between the two adds no pipeline stage.

Top module: `dbg_fetch_overlay`

## Requirements
- R1: After reset `dbg_active` is 0 and `fetch_data` equals `ram_rdata`.
- R2: A fetch address in 0x1F8..0x1FF presented while `dbg_active` is 1 yields, on `fetch_data` in the next cycle, the overlay word at index `fetch_addr[2:0]`. The flag value used is the one present when the address was sampled.
- R3: A fetch address below 0x1F8 yields `ram_rdata` in the next cycle, whatever the flag state.
- R4: A fetch address in 0x1F8..0x1FF presented while `dbg_active` is 0 yields `ram_rdata` unchanged.
- R5: A `dbg_enter` pulse sets `dbg_active` from the next cycle. The flag then holds until a `dbg_clear` pulse clears it. When both pulses arrive in the same cycle, entry wins.
- R6: `entry_vec` is 0x1F8 when `short_mode` is 0 and 0x1FE when `short_mode` is 1.
- R7: `seq_addr` equals `fetch_addr + 1` modulo 512, so 0x1FF is followed by 0x000.
- R8: An overlay write (`ovl_we`, 3-bit `ovl_waddr`, 32-bit `ovl_wdata`) is stored when `dbg_active` is 0. It is ignored when `dbg_active` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_addr | input | 9 | Instruction word address sampled this cycle |
| ram_rdata | input | 32 | Core RAM read word for the address sampled last cycle |
| fetch_data | output | 32 | Opcode delivered to the core |
| dbg_enter | input | 1 | Debug entry pulse, sets the flag |
| dbg_clear | input | 1 | Clear pulse from the final stub instruction |
| dbg_active | output | 1 | Debug-active flag |
| short_mode | input | 1 | Selects the short-stub entry vector |
| entry_vec | output | 9 | Address to vector to on debug entry |
| seq_addr | output | 9 | Sequential successor of `fetch_addr` with wrap |
| ovl_we | input | 1 | Overlay write enable |
| ovl_waddr | input | 3 | Overlay word index |
| ovl_wdata | input | 32 | Overlay write word |

## Verification
The bench targets the edges of the window. Addresses 0x1F7 and 0x1F8 are fetched on both sides of the flag; a decoder that is off by one would substitute or leak a core RAM word there. It clears the flag in the same cycle as a window fetch. A design that qualifies the output with the current flag instead of the sampled one would then return RAM data for the last stub word. It walks the short stub from the entry vector through 0x1FE and 0x1FF to 0x000, which catches a wrong vector or a successor that runs on into 0x200. It also writes the overlay while the flag is set: a missing lock would patch the stub in the middle of the handler, and a later fetch would show the new word.

// File: rtl/dfo_pkg.sv
package dfo_pkg;
  localparam int unsigned ADDR_W    = 9;
  localparam int unsigned DATA_W    = 32;
  localparam int unsigned WIN_AW    = 3;
  localparam int unsigned SHORT_LEN = 2;

  typedef enum logic {
    ENTRY_FULL  = 1'b0,
    ENTRY_SHORT = 1'b1
  } entry_mode_e;
endpackage

// File: rtl/dfo_flag.sv
module dfo_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic active_o
);
  logic active_d, active_q;

  // Entry has priority over clear.
  always_comb begin
    active_d = active_q;
    if (clr_i) active_d = 1'b0;
    if (set_i) active_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) active_q <= 1'b0;
    else        active_q <= active_d;
  end

  assign active_o = active_q;
endmodule

// File: rtl/dfo_window.sv
module dfo_window
  import dfo_pkg::*;
#(
  parameter int unsigned ADDR_W    = dfo_pkg::ADDR_W,
  parameter int unsigned WIN_AW    = dfo_pkg::WIN_AW,
  parameter int unsigned SHORT_LEN = dfo_pkg::SHORT_LEN
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              short_i,
  output logic              hit_o,
  output logic [ADDR_W-1:0] seq_o,
  output logic [ADDR_W-1:0] vec_o
);
  localparam int unsigned TOP_W = ADDR_W - WIN_AW;
  localparam logic [ADDR_W-1:0] FULL_VEC  = {{TOP_W{1'b1}}, {WIN_AW{1'b0}}};
  localparam logic [ADDR_W-1:0] SHORT_VEC = ~ADDR_W'(SHORT_LEN - 1);

  entry_mode_e mode;

  assign mode  = entry_mode_e'(short_i);
  assign hit_o = &addr_i[ADDR_W-1:WIN_AW];
  // Natural modulo-2^ADDR_W increment gives the wrap to zero.
  assign seq_o = addr_i + ADDR_W'(1);

  always_comb begin
    case (mode)
      ENTRY_SHORT: vec_o = SHORT_VEC;
      default:     vec_o = FULL_VEC;
    endcase
  end
endmodule

// File: rtl/dfo_store.sv
module dfo_store #(
  parameter int unsigned DATA_W = dfo_pkg::DATA_W,
  parameter int unsigned WIN_AW = dfo_pkg::WIN_AW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [WIN_AW-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              lock_i,
  input  logic              rd_en_i,
  input  logic [WIN_AW-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << WIN_AW;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DEPTH-1:0]  word_en;
  logic [DATA_W-1:0] rdata_d, rdata_q;
  logic              wr_ok;

  assign wr_ok = we_i & ~lock_i;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      word_en[i] = wr_ok && (waddr_i == WIN_AW'(i));
    end
    rdata_d = mem[raddr_i];
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (word_en[i]) mem[i] <= wdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rdata_q <= '0;
    else if (rd_en_i) rdata_q <= rdata_d;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/dbg_fetch_overlay.sv
module dbg_fetch_overlay
  import dfo_pkg::*;
#(
  parameter int unsigned ADDR_W    = dfo_pkg::ADDR_W,
  parameter int unsigned DATA_W    = dfo_pkg::DATA_W,
  parameter int unsigned WIN_AW    = dfo_pkg::WIN_AW,
  parameter int unsigned SHORT_LEN = dfo_pkg::SHORT_LEN
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] fetch_addr,
  input  logic [DATA_W-1:0] ram_rdata,
  output logic [DATA_W-1:0] fetch_data,
  input  logic              dbg_enter,
  input  logic              dbg_clear,
  output logic              dbg_active,
  input  logic              short_mode,
  output logic [ADDR_W-1:0] entry_vec,
  output logic [ADDR_W-1:0] seq_addr,
  input  logic              ovl_we,
  input  logic [WIN_AW-1:0] ovl_waddr,
  input  logic [DATA_W-1:0] ovl_wdata
);
  logic              win_hit;
  logic              sel_d, sel_q;
  logic [DATA_W-1:0] ovl_rdata;

  dfo_flag u_flag (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_i    (dbg_enter),
    .clr_i    (dbg_clear),
    .active_o (dbg_active)
  );

  dfo_window #(.ADDR_W(ADDR_W), .WIN_AW(WIN_AW), .SHORT_LEN(SHORT_LEN)) u_win (
    .addr_i  (fetch_addr),
    .short_i (short_mode),
    .hit_o   (win_hit),
    .seq_o   (seq_addr),
    .vec_o   (entry_vec)
  );

  dfo_store #(.DATA_W(DATA_W), .WIN_AW(WIN_AW)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (ovl_we),
    .waddr_i (ovl_waddr),
    .wdata_i (ovl_wdata),
    .lock_i  (dbg_active),
    .rd_en_i (win_hit),
    .raddr_i (fetch_addr[WIN_AW-1:0]),
    .rdata_o (ovl_rdata)
  );

  // Qualifier captured with the address, aligned to the RAM read latency.
  assign sel_d = win_hit & dbg_active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= 1'b0;
    else        sel_q <= sel_d;
  end

  assign fetch_data = sel_q ? ovl_rdata : ram_rdata;
endmodule

// File: rtl/dfo_checker.sv
module dfo_checker #(
  parameter int unsigned ADDR_W    = dfo_pkg::ADDR_W,
  parameter int unsigned DATA_W    = dfo_pkg::DATA_W,
  parameter int unsigned WIN_AW    = dfo_pkg::WIN_AW,
  parameter int unsigned SHORT_LEN = dfo_pkg::SHORT_LEN
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] fetch_addr,
  input logic [DATA_W-1:0] ram_rdata,
  input logic [DATA_W-1:0] fetch_data,
  input logic              dbg_enter,
  input logic              dbg_clear,
  input logic              dbg_active,
  input logic              short_mode,
  input logic [ADDR_W-1:0] entry_vec,
  input logic [ADDR_W-1:0] seq_addr
);
  localparam logic [ADDR_W-1:0] WIN_BASE = ADDR_W'((1 << ADDR_W) - (1 << WIN_AW));
  localparam logic [ADDR_W-1:0] SHORT_AT = ADDR_W'((1 << ADDR_W) - SHORT_LEN);
  localparam logic [ADDR_W-1:0] LAST     = ADDR_W'((1 << ADDR_W) - 1);

  assert_enter_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_enter |=> dbg_active);
  assert_flag_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_active && !dbg_clear) |=> dbg_active);
  assert_clear_drops_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_clear && !dbg_enter) |=> !dbg_active);
  assert_short_vector_R6: assert property (@(posedge clk) disable iff (!rst_n)
    short_mode |-> (entry_vec == SHORT_AT));
  assert_full_vector_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !short_mode |-> (entry_vec == WIN_BASE));
  assert_wrap_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_addr == LAST) |-> (seq_addr == '0));
  assert_outside_ram_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_addr < WIN_BASE) |=> (fetch_data == ram_rdata));
  assert_idle_ram_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !dbg_active |=> (fetch_data == ram_rdata));
endmodule

bind dbg_fetch_overlay dfo_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WIN_AW(WIN_AW), .SHORT_LEN(SHORT_LEN)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .fetch_addr (fetch_addr),
  .ram_rdata  (ram_rdata),
  .fetch_data (fetch_data),
  .dbg_enter  (dbg_enter),
  .dbg_clear  (dbg_clear),
  .dbg_active (dbg_active),
  .short_mode (short_mode),
  .entry_vec  (entry_vec),
  .seq_addr   (seq_addr)
);

// File: tb/dbg_fetch_overlay_test.sv
`timescale 1ns/1ps
module dbg_fetch_overlay_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [8:0]  fetch_addr;
  logic [31:0] ram_rdata;
  logic [31:0] fetch_data;
  logic        dbg_enter, dbg_clear, dbg_active, short_mode;
  logic [8:0]  entry_vec, seq_addr;
  logic        ovl_we;
  logic [2:0]  ovl_waddr;
  logic [31:0] ovl_wdata;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;
  logic [31:0] ovl_m [8];
  bit act_m = 0;

  always #2 clk = ~clk;

  dbg_fetch_overlay uut (
    .clk(clk), .rst_n(rst_n), .fetch_addr(fetch_addr), .ram_rdata(ram_rdata),
    .fetch_data(fetch_data), .dbg_enter(dbg_enter), .dbg_clear(dbg_clear),
    .dbg_active(dbg_active), .short_mode(short_mode), .entry_vec(entry_vec),
    .seq_addr(seq_addr), .ovl_we(ovl_we), .ovl_waddr(ovl_waddr), .ovl_wdata(ovl_wdata)
  );

  // Row: {flag wanted (1), fetch address (9), RAM word (32)}
  localparam logic [41:0] VEC [12] = '{
    {1'b0, 9'h010, 32'h1111_0001}, {1'b0, 9'h1F8, 32'hC0DE_0001},
    {1'b0, 9'h1FF, 32'hC0DE_0002}, {1'b0, 9'h1F7, 32'hC0DE_0003},
    {1'b1, 9'h1F8, 32'h5555_0001}, {1'b1, 9'h1FB, 32'h5555_0002},
    {1'b1, 9'h1FF, 32'h5555_0003}, {1'b1, 9'h1F7, 32'h5555_0004},
    {1'b1, 9'h000, 32'h5555_0005}, {1'b1, 9'h1FD, 32'h5555_0006},
    {1'b0, 9'h1FC, 32'h7777_0001}, {1'b1, 9'h1FE, 32'h7777_0002}
  };

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic fetch(input logic [8:0] a, input logic [31:0] r, input logic [31:0] exp,
                       input string tag);
    @(negedge clk); fetch_addr = a;
    @(negedge clk); ram_rdata = r;
    #1 check(tag, fetch_data, exp);
  endtask

  task automatic enter();
    @(negedge clk); dbg_enter = 1'b1;
    @(negedge clk); dbg_enter = 1'b0;
    act_m = 1;
  endtask

  task automatic leave();
    @(negedge clk); dbg_clear = 1'b1;
    @(negedge clk); dbg_clear = 1'b0;
    act_m = 0;
  endtask

  task automatic write_ovl(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); ovl_we = 1'b1; ovl_waddr = a; ovl_wdata = d;
    @(negedge clk); ovl_we = 1'b0;
    if (!act_m) ovl_m[a] = d;
  endtask

  function automatic logic [31:0] expect_word(bit act, logic [8:0] a, logic [31:0] r);
    return (act && a >= 9'h1F8) ? ovl_m[a[2:0]] : r;
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; fetch_addr = '0; ram_rdata = '0; dbg_enter = 0; dbg_clear = 0;
    short_mode = 0; ovl_we = 0; ovl_waddr = '0; ovl_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    ram_rdata = 32'hDEAD_0000;
    #1;
    check("R1 flag", {31'b0, dbg_active}, 32'd0);
    check("R1 data", fetch_data, 32'hDEAD_0000);

    for (int i = 0; i < 8; i++) write_ovl(3'(i), 32'hA500_0000 | (32'(i) * 32'h111));

    // Table walk
    foreach (VEC[k]) begin
      bit          want = VEC[k][41];
      logic [8:0]  a    = VEC[k][40:32];
      logic [31:0] r    = VEC[k][31:0];
      if (want && !act_m) enter();
      if (!want && act_m) leave();
      fetch(a, r, expect_word(want, a, r),
            (a < 9'h1F8) ? "R3 outside" : (want ? "R2 overlay" : "R4 idle window"));
    end
    leave();

    // R5: simultaneous enter and clear, entry wins; flag then holds
    @(negedge clk); dbg_enter = 1; dbg_clear = 1;
    @(negedge clk); dbg_enter = 0; dbg_clear = 0; act_m = 1;
    check("R5 enter wins", {31'b0, dbg_active}, 32'd1);
    repeat (5) @(negedge clk);
    check("R5 hold", {31'b0, dbg_active}, 32'd1);

    // R8: write while active is ignored
    write_ovl(3'd3, 32'hBAD0_BAD0);
    fetch(9'h1FB, 32'h0, ovl_m[3], "R8 locked write");

    // R2: clear in the same cycle as a window fetch; data follows sampled flag
    @(negedge clk); fetch_addr = 9'h1F9; dbg_clear = 1;
    @(negedge clk); dbg_clear = 0; act_m = 0; ram_rdata = 32'h0BAD_F00D;
    #1 check("R2 sampled flag", fetch_data, ovl_m[1]);
    check("R5 cleared", {31'b0, dbg_active}, 32'd0);

    // R8: write while idle is taken
    write_ovl(3'd7, 32'h600D_0007);
    write_ovl(3'd6, 32'h600D_0006);

    // R6 vectors
    @(negedge clk); short_mode = 0; #1 check("R6 full vector", 32'(entry_vec), 32'h1F8);
    @(negedge clk); short_mode = 1; #1 check("R6 short vector", 32'(entry_vec), 32'h1FE);

    // R7 successor
    @(negedge clk); fetch_addr = 9'h0FF; #1 check("R7 carry", 32'(seq_addr), 32'h100);
    @(negedge clk); fetch_addr = 9'h1FF; #1 check("R7 wrap", 32'(seq_addr), 32'h000);

    // Short-stub walk: 0x1FE, 0x1FF from overlay, then 0x000 from RAM
    enter();
    fetch(entry_vec, 32'h1234_0000, ovl_m[6], "R2 stub word 0 / R8 idle write");
    fetch(seq_addr, 32'h1234_0001, ovl_m[7], "R2 stub word 1 / R8 idle write");
    check("R7 stub wraps", 32'(seq_addr), 32'h000);
    fetch(seq_addr, 32'h1234_0002, 32'h1234_0002, "R3 after wrap");
    leave();

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule